// File: doc/BRIEF.md
# Microcode Store Loader with 16-bit Staging

This block fills a 256-entry store of 64-bit microcode words from a host that only has a 16-bit register bus. The host arms loading by writing a key value to a mode register. It then writes the four 16-bit lanes of the next word into staging registers. A final write to the commit register copies the assembled word into the entry named by the low byte of that write.

The staging lanes are not cleared by a commit, so one word can be copied to several entries. The microcode engine reads the store through its own port. That port returns the word one cycle after the address is applied. It also returns two flags: one marks an all-zero word, which the engine treats as a no-operation, and one marks an address in the reserved entry-point region at the top of the store.

Top module: `mst_loader`

## Requirements
- R1: A commit (write to byte address 0x10 while load mode is active) stores the assembled 64-bit word at the entry given by bits 7:0 of the commit write data; the store has 256 entries.
- R2: Lane registers sit at byte addresses 0x20, 0x22, 0x24 and 0x26, and supply word bits 63:48, 47:32, 31:16 and 15:0 respectively.
- R3: Writing 0x0003 to the mode register at 0x30 activates load mode; writing any other value there deactivates it; reading 0x30 returns 0x0003 while active and 0x0000 otherwise.
- R4: A commit written while load mode is inactive leaves the store unchanged.
- R5: A commit does not change the lane registers, so repeated commits with no lane writes store the same word at each entry.
- R6: The engine port presents the word at `eng_addr` on `eng_word` one clock after the address is sampled.
- R7: `eng_nop` is high exactly when the returned word is all zero.
- R8: `eng_entry` is high exactly when the returned word came from an entry at index 240 or above.
- R9: Reset clears the lanes and load mode but keeps the store contents.
- R10: Lanes can be read back at their addresses and can be written whatever the mode; reads of any unmapped address return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 16 | Register write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 16 | Register read data (combinational) |
| eng_addr | input | 8 | Engine read address |
| eng_word | output | 64 | Engine read word, one cycle after the address |
| eng_nop | output | 1 | Returned word is all zero |
| eng_entry | output | 1 | Returned word is from the entry-point region |

## Verification
The assertions assume that the engine port is driven from reset onward, and that the host never commits to an entry while the engine reads that same entry in the same cycle. The bench holds `eng_addr` at a known value from time zero. It issues every bus write and engine read on the falling edge, and it reads back only entries that it has written since time zero. It also keeps each engine read apart from the cycle of a commit.

// File: rtl/mst_pkg.sv
package mst_pkg;
    localparam int BUS_W   = 16;
    localparam int LANES   = 4;
    localparam int LANE_W  = $clog2(LANES);
    localparam int WORD_W  = BUS_W * LANES;
    localparam int DEPTH   = 256;
    localparam int IDX_W   = $clog2(DEPTH);
    localparam int ENTRY_N = 16;
    localparam int AW      = 8;

    localparam logic [AW-1:0]    A_COMMIT = 8'h10;
    localparam logic [AW-1:0]    A_LANE0  = 8'h20;
    localparam logic [AW-1:0]    A_CFG    = 8'h30;
    localparam logic [BUS_W-1:0] LOAD_KEY = 16'h0003;

    typedef enum logic [1:0] {DEC_NONE, DEC_CFG, DEC_LANE, DEC_COMMIT} dec_e;

    typedef struct packed {
        dec_e              kind;
        logic [LANE_W-1:0] lane;
    } dec_t;

    function automatic dec_t decode(input logic [AW-1:0] a);
        dec_t d;
        d.kind = DEC_NONE;
        d.lane = a[LANE_W:1];
        if (a == A_CFG)
            d.kind = DEC_CFG;
        else if (a == A_COMMIT)
            d.kind = DEC_COMMIT;
        else if (a[AW-1:LANE_W+1] == A_LANE0[AW-1:LANE_W+1] && !a[0])
            d.kind = DEC_LANE;
        return d;
    endfunction

    function automatic logic in_entry_region(input logic [IDX_W-1:0] i);
        return int'(i) >= DEPTH - ENTRY_N;
    endfunction
endpackage

// File: rtl/mst_stage.sv
module mst_stage
    import mst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              load_mode,
    output logic              commit_req,
    output logic [IDX_W-1:0]  commit_idx,
    output logic [WORD_W-1:0] staged_word
);
    logic [LANES-1:0][BUS_W-1:0] lanes;
    dec_t dec;

    assign dec = decode(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            lanes     <= '0;
            load_mode <= 1'b0;
        end else if (bus_we) begin
            case (dec.kind)
                DEC_CFG:  load_mode <= (bus_wdata == LOAD_KEY);
                DEC_LANE: lanes[dec.lane] <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // lane 0 is the most significant quarter
    for (genvar g = 0; g < LANES; g++) begin : g_pack
        assign staged_word[WORD_W-1-g*BUS_W -: BUS_W] = lanes[g];
    end

    assign commit_req = bus_we && dec.kind == DEC_COMMIT;
    assign commit_idx = bus_wdata[IDX_W-1:0];

    always_comb begin
        case (dec.kind)
            DEC_CFG:  bus_rdata = load_mode ? LOAD_KEY : '0;
            DEC_LANE: bus_rdata = lanes[dec.lane];
            default:  bus_rdata = '0;
        endcase
    end

    AST_KEY_ARMS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CFG && bus_wdata == LOAD_KEY) |=> load_mode); // R3
    AST_OTHER_DISARMS: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == A_CFG && bus_wdata != LOAD_KEY) |=> !load_mode); // R3
    AST_COMMIT_KEEPS_LANES: assert property (@(posedge clk) disable iff (rst)
        commit_req |=> $stable(staged_word)); // R5
    AST_RESET_DISARMS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!load_mode && staged_word == '0)); // R9
endmodule

// File: rtl/mst_store.sv
module mst_store
    import mst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic              rd_nop,
    output logic              rd_entry
);
    logic [WORD_W-1:0] mem [DEPTH];

    // store contents survive reset
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_word;
        rd_word <= mem[rd_idx];
        rd_nop  <= (mem[rd_idx] == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) rd_entry <= 1'b0;
        else     rd_entry <= in_entry_region(rd_idx);
    end

    AST_NOP_MATCHES_WORD: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (rd_nop == (rd_word == '0))); // R7
    AST_ENTRY_FLAG: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (rd_entry == (int'($past(rd_idx)) >= DEPTH - ENTRY_N))); // R8
endmodule

// File: rtl/mst_loader.sv
module mst_loader
    import mst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [IDX_W-1:0]  eng_addr,
    output logic [WORD_W-1:0] eng_word,
    output logic              eng_nop,
    output logic              eng_entry
);
    logic              load_mode;
    logic              commit_req;
    logic [IDX_W-1:0]  commit_idx;
    logic [WORD_W-1:0] staged_word;
    logic              wr_en;

    mst_stage u_stage (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_rdata  (bus_rdata),
        .load_mode  (load_mode),
        .commit_req (commit_req),
        .commit_idx (commit_idx),
        .staged_word(staged_word)
    );

    assign wr_en = commit_req && load_mode;

    mst_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (commit_idx),
        .wr_word (staged_word),
        .rd_idx  (eng_addr),
        .rd_word (eng_word),
        .rd_nop  (eng_nop),
        .rd_entry(eng_entry)
    );
endmodule

// File: tb/tb_mst_loader.sv
module tb_mst_loader;
    logic        clk = 0;
    logic        rst = 1;
    logic [7:0]  bus_addr = 0;
    logic [15:0] bus_wdata = 0;
    logic        bus_we = 0;
    logic [15:0] bus_rdata;
    logic [7:0]  eng_addr = 0;
    logic [63:0] eng_word;
    logic        eng_nop, eng_entry;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    mst_loader dut (.*);

    localparam int NV = 6;
    localparam logic [71:0] VEC [NV] = '{
        {8'h00, 64'h0123_4567_89AB_CDEF},
        {8'h05, 64'h0000_0000_0000_0000},
        {8'hEF, 64'hFFFF_0000_FFFF_0001},
        {8'hF0, 64'hDEAD_BEEF_CAFE_F00D},
        {8'hFF, 64'h8000_0000_0000_0000},
        {8'h80, 64'h0000_0000_0000_0001}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd_bus(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic load_lanes(input logic [63:0] w);
        wr(8'h20, w[63:48]); wr(8'h22, w[47:32]);
        wr(8'h24, w[31:16]); wr(8'h26, w[15:0]);
    endtask

    task automatic eng_rd(input logic [7:0] a, output logic [63:0] w,
                          output logic n, output logic e);
        @(negedge clk);
        eng_addr = a;
        @(negedge clk);
        w = eng_word; n = eng_nop; e = eng_entry;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [63:0] w, w2;
        logic n, e;
        repeat (3) @(negedge clk);
        rst = 0;

        // R9 R3 R10: reset state
        rd_bus(8'h30, d); chk("R3 mode after reset", d, 0);
        for (int i = 0; i < 4; i++) begin
            rd_bus(8'h20 + 8'(2*i), d); chk("R9 lane cleared", d, 0);
        end

        // R2 R10: lane write/readback without load mode
        load_lanes(64'h1111_2222_3333_4444);
        rd_bus(8'h24, d); chk("R10 lane readback", d, 16'h3333);
        rd_bus(8'h40, d); chk("R10 unmapped", d, 0);

        // R3 arm
        wr(8'h30, 16'h0003);
        rd_bus(8'h30, d); chk("R3 armed", d, 16'h0003);

        // R1 R2 R7 R8: table walk
        for (int i = 0; i < NV; i++) begin
            load_lanes(VEC[i][63:0]);
            wr(8'h10, {8'h00, VEC[i][71:64]});
        end
        for (int i = 0; i < NV; i++) begin
            eng_rd(VEC[i][71:64], w, n, e);
            chk("R1 R2 word", w, VEC[i][63:0]);
            chk("R7 nop flag", n, VEC[i][63:0] == 0);
            chk("R8 entry flag", e, VEC[i][71:64] >= 8'd240);
        end

        // R6: one-cycle latency
        @(negedge clk); eng_addr = 8'hF0;
        @(negedge clk); eng_addr = 8'h00;
        #1 chk("R6 old word held", eng_word, 64'hDEAD_BEEF_CAFE_F00D);
        @(negedge clk); chk("R6 new word", eng_word, 64'h0123_4567_89AB_CDEF);

        // R5: replicate staged word (lanes hold last vector)
        wr(8'h10, 16'h0006); wr(8'h10, 16'h0007);
        rd_bus(8'h26, d); chk("R5 lane kept", d, 16'h0001);
        eng_rd(8'h06, w, n, e); chk("R5 copy a", w, 64'h1);
        eng_rd(8'h07, w, n, e); chk("R5 copy b", w, 64'h1);

        // R3 R4: disarm, commit ignored
        wr(8'h30, 16'h0002);
        rd_bus(8'h30, d); chk("R3 disarmed", d, 0);
        load_lanes(64'hAAAA_BBBB_CCCC_DDDD);
        wr(8'h10, 16'h0005);
        eng_rd(8'h05, w, n, e); chk("R4 store unchanged", w, 0);
        chk("R4 nop still", n, 1);

        // R9: reset keeps store
        eng_rd(8'h00, w2, n, e);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        rd_bus(8'h20, d); chk("R9 lane cleared again", d, 0);
        rd_bus(8'h30, d); chk("R9 mode cleared", d, 0);
        eng_rd(8'h00, w, n, e); chk("R9 store kept", w, w2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule